// File: doc/BRIEF.md
# 4x4 Integer Forward Transform Engine

This block takes a 4x4 tile of signed 16-bit residual samples and turns it into sixteen signed 16-bit transform coefficients using two fixed-point passes. The first pass runs across each incoming row. It uses a sum/difference butterfly, pre-scales the four terms by eight, and rounds the two odd outputs with multiplies by 2217 and 5352. The second pass runs down each column of the first-pass tile. It adds a bias of 7 to the sum path, scales the even outputs down by 16, and narrows the odd outputs after a 16-bit right shift. The position-4 output gets a +1 correction whenever its column difference is nonzero.

Samples arrive one row of four per accepted beat on a valid/ready input. The engine then spends one cycle on the column pass and presents the coefficients in raster order, one row of four per beat, on a valid/ready output. A new tile is accepted only after the last coefficient row has been taken. All additions and subtractions wrap modulo 2^16. Only the multiply-accumulate paths are 32 bits wide before they are narrowed.

Top module: `fdct4_engine`

## Requirements
- R1: Row pass, even outputs. For row samples x0..x3, the pass forms s=x0+x3, t=x1+x2, u=x1−x2 and v=x0−x3, each wrapped to 16 bits. It shifts each term left by 3 with wrap, then gives element 0 as s+t and element 2 as s−t, both wrapped and unrounded.
- R2: Row pass, odd outputs. Element 1 is the low 16 bits of (u·2217 + v·5352 + 14500) arithmetically shifted right by 12. Element 3 is the low 16 bits of (v·2217 − u·5352 + 7500) arithmetically shifted right by 12. Both sums are formed at 32 bits.
- R3: Column pass, even outputs. For column j of the row-pass tile, with e0, e4, e8 and e12 at positions j, 4+j, 8+j and 12+j: s = e0+e12+7, t = e4+e8, u = e4−e8 and v = e0−e12, all wrapped to 16 bits. Coefficient j is (s+t)>>>4 and coefficient 8+j is (s−t)>>>4, with the sum wrapped to 16 bits before the shift.
- R4: Coefficient 4+j is the low 16 bits of (u·2217 + v·5352 + 12000)>>>16, plus 1 (wrapping) when v is nonzero.
- R5: Coefficient 12+j is the low 16 bits of (v·2217 − u·5352 + 51000)>>>16, with no correction.
- R6: Input handshake. Each lane is 16 bits, and lane i (element i of the row) sits at in_data[16i+15:16i]. in_ready is high while a tile is being loaded. Four accepted beats fill rows 0 to 3 in order. From the cycle after the fourth acceptance, in_ready stays low until the tile has been drained.
- R7: Output. out_valid rises two cycles after the fourth input acceptance. Coefficient rows 0 to 3 (positions 4k..4k+3, with position 4k+i in lane i) leave on consecutive accepted beats. While out_valid is high and out_ready is low, out_valid and out_data hold.
- R8: After reset, in_ready is 1 and out_valid is 0.
- R9: in_ready and out_valid are never high together. in_ready returns to 1 in the cycle after the last coefficient row is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input row is offered |
| in_ready | output | 1 | Engine accepts an input row |
| in_data | input | 64 | Four signed 16-bit samples of one row |
| out_valid | output | 1 | A coefficient row is offered |
| out_ready | input | 1 | Consumer takes the coefficient row |
| out_data | output | 64 | Four signed 16-bit coefficients of one row |

## Verification
Full-scale tiles of all 32767 and all −32768 drive the butterflies and the pre-scale into 16-bit wrap. A design that widened these intermediates, or saturated them, would return different even coefficients. The all-zero tile and single-impulse tiles separate the nonzero correction on position 4 from the other outputs. A design that applied the correction unconditionally, or to position 12, would be off by one there. Random output stalls check that a held coefficient row does not advance or change. Back-to-back tiles check that input is refused until the fourth coefficient row is taken.

// File: rtl/fdct4_pkg.sv
package fdct4_pkg;

  localparam int unsigned SAMP_W  = 16;
  localparam int unsigned LANES   = 4;
  localparam int unsigned TILE_N  = LANES * LANES;
  localparam int unsigned ROW_W   = LANES * SAMP_W;
  localparam int unsigned TILE_W  = TILE_N * SAMP_W;
  localparam int unsigned IDX_W   = $clog2(LANES);

  localparam int unsigned PRE_SH  = 3;
  localparam int          ROW_SH  = 12;
  localparam int          COL_SH  = 16;
  localparam int unsigned EVEN_SH = 4;

  localparam logic signed [31:0] K_LO     = 32'sd2217;
  localparam logic signed [31:0] K_HI     = 32'sd5352;
  localparam logic signed [31:0] RND_R1   = 32'sd14500;
  localparam logic signed [31:0] RND_R3   = 32'sd7500;
  localparam logic signed [31:0] RND_C4   = 32'sd12000;
  localparam logic signed [31:0] RND_C12  = 32'sd51000;
  localparam logic signed [15:0] COL_BIAS = 16'sd7;

  typedef logic signed [SAMP_W-1:0] s16_t;
  typedef logic [LANES-1:0][SAMP_W-1:0] quad_t;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_COL   = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;

  // Two products plus offset, 32-bit accumulate, arithmetic shift, narrow.
  function automatic s16_t mac_narrow(input s16_t p, input logic signed [31:0] kp,
                                      input s16_t q, input logic signed [31:0] kq,
                                      input logic signed [31:0] rnd, input int sh);
    logic signed [31:0] pw;
    logic signed [31:0] qw;
    logic signed [31:0] acc;
    pw  = 32'(p);
    qw  = 32'(q);
    acc = pw * kp + qw * kq + rnd;
    return s16_t'(acc >>> sh);
  endfunction

  // First pass on one row.
  function automatic quad_t row_xform(input quad_t x);
    s16_t x0, x1, x2, x3;
    s16_t s, t, u, v;
    quad_t y;
    x0 = x[0]; x1 = x[1]; x2 = x[2]; x3 = x[3];
    s = x0 + x3;
    t = x1 + x2;
    u = x1 - x2;
    v = x0 - x3;
    s = s <<< PRE_SH;
    t = t <<< PRE_SH;
    u = u <<< PRE_SH;
    v = v <<< PRE_SH;
    y[0] = s + t;
    y[2] = s - t;
    y[1] = mac_narrow(u, K_LO, v, K_HI, RND_R1, ROW_SH);
    y[3] = mac_narrow(v, K_LO, u, -K_HI, RND_R3, ROW_SH);
    return y;
  endfunction

  // Second pass on one column: e[0..3] are tile positions j, 4+j, 8+j, 12+j;
  // result element k belongs to position 4k+j.
  function automatic quad_t col_xform(input quad_t e);
    s16_t e0, e4, e8, e12;
    s16_t s, t, u, v, sum, dif, odd;
    quad_t y;
    e0 = e[0]; e4 = e[1]; e8 = e[2]; e12 = e[3];
    s   = e0 + e12 + COL_BIAS;
    t   = e4 + e8;
    u   = e4 - e8;
    v   = e0 - e12;
    sum = s + t;
    dif = s - t;
    y[0] = sum >>> EVEN_SH;
    y[2] = dif >>> EVEN_SH;
    odd  = mac_narrow(u, K_LO, v, K_HI, RND_C4, COL_SH);
    y[1] = odd + s16_t'(v != 16'sd0);
    y[3] = mac_narrow(v, K_LO, u, -K_HI, RND_C12, COL_SH);
    return y;
  endfunction

endpackage

// File: rtl/fdct4_row_unit.sv
module fdct4_row_unit
  import fdct4_pkg::*;
(
  input  quad_t samp,
  output quad_t coef
);
  assign coef = row_xform(samp);
endmodule

// File: rtl/fdct4_col_unit.sv
module fdct4_col_unit
  import fdct4_pkg::*;
(
  input  quad_t elem,
  output quad_t coef
);
  assign coef = col_xform(elem);
endmodule

// File: rtl/fdct4_tile_reg.sv
module fdct4_tile_reg #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 4,
  parameter int unsigned W    = 16,
  localparam int unsigned RW  = COLS * W,
  localparam int unsigned AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               row_we,
  input  logic [AW-1:0]      row_sel,
  input  logic [RW-1:0]      row_d,
  input  logic               all_we,
  input  logic [ROWS*RW-1:0] all_d,
  output logic [ROWS*RW-1:0] q
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [RW-1:0] line;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line <= '0;
      end else if (all_we) begin
        line <= all_d[r*RW +: RW];
      end else if (row_we && (row_sel == AW'(r))) begin
        line <= row_d;
      end
    end
    assign q[r*RW +: RW] = line;
  end
endmodule

// File: rtl/fdct4_engine.sv
module fdct4_engine
  import fdct4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ROW_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ROW_W-1:0]  out_data
);
  phase_e           phase;
  logic [IDX_W-1:0] in_row;
  logic [IDX_W-1:0] out_row;

  logic in_fire, out_fire;
  logic last_row_acc;   // fourth row of a tile accepted
  logic last_out_take;  // fourth coefficient row taken

  quad_t             row_res;
  logic [TILE_W-1:0] mid_tile;
  logic [TILE_W-1:0] col_tile;
  logic [TILE_W-1:0] res_tile;

  assign in_ready      = (phase == PH_LOAD);
  assign out_valid     = (phase == PH_DRAIN);
  assign in_fire       = in_valid && in_ready;
  assign out_fire      = out_valid && out_ready;
  assign last_row_acc  = in_fire && (in_row == IDX_W'(LANES - 1));
  assign last_out_take = out_fire && (out_row == IDX_W'(LANES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_LOAD;
      in_row  <= '0;
      out_row <= '0;
    end else begin
      unique case (phase)
        PH_LOAD: if (in_fire) begin
          in_row <= in_row + 1'b1;
          if (last_row_acc) phase <= PH_COL;
        end
        PH_COL: begin
          phase   <= PH_DRAIN;
          out_row <= '0;
        end
        PH_DRAIN: if (out_fire) begin
          out_row <= out_row + 1'b1;
          if (last_out_take) begin
            phase  <= PH_LOAD;
            in_row <= '0;
          end
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

  fdct4_row_unit i_row (
    .samp (quad_t'(in_data)),
    .coef (row_res)
  );

  fdct4_tile_reg #(.ROWS(LANES), .COLS(LANES), .W(SAMP_W)) i_mid (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_we  (in_fire),
    .row_sel (in_row),
    .row_d   (row_res),
    .all_we  (1'b0),
    .all_d   ({TILE_W{1'b0}}),
    .q       (mid_tile)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_col
    quad_t col_in, col_out;
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign col_in[k] = mid_tile[(k*LANES + j)*SAMP_W +: SAMP_W];
      assign col_tile[(k*LANES + j)*SAMP_W +: SAMP_W] = col_out[k];
    end
    fdct4_col_unit i_col (
      .elem (col_in),
      .coef (col_out)
    );
  end

  fdct4_tile_reg #(.ROWS(LANES), .COLS(LANES), .W(SAMP_W)) i_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_we  (1'b0),
    .row_sel ({IDX_W{1'b0}}),
    .row_d   ({ROW_W{1'b0}}),
    .all_we  (phase == PH_COL),
    .all_d   (col_tile),
    .q       (res_tile)
  );

  assign out_data = res_tile[out_row*ROW_W +: ROW_W];

endmodule

// File: rtl/fdct4_engine_chk.sv
module fdct4_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        last_row_acc,
  input logic        last_out_take
);
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r6_closed_after_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    last_row_acc |=> (!in_ready && !out_valid));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_drain_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !last_out_take) |=> out_valid);

  a_r9_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    last_out_take |=> (in_ready && !out_valid));
endmodule

bind fdct4_engine fdct4_engine_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .last_row_acc  (last_row_acc),
  .last_out_take (last_out_take)
);

// File: tb/test_fdct4_engine.sv
module test_fdct4_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;

  int total = 0;
  int bad = 0;
  shortint blk[16];
  shortint exp_y[16];

  always #10 clk = ~clk;

  fdct4_engine i_fdct4_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, got no end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic shortint wr(input int v);
    return shortint'(v);
  endfunction

  // Behavioural reference, written on plain ints with explicit wrapping.
  function automatic void compute_expect();
    shortint m[16];
    for (int r = 0; r < 4; r++) begin
      int x0 = blk[4*r], x1 = blk[4*r+1], x2 = blk[4*r+2], x3 = blk[4*r+3];
      int aa = wr(wr(x0 + x3) * 8);
      int bb = wr(wr(x1 + x2) * 8);
      int cc = wr(wr(x1 - x2) * 8);
      int dd = wr(wr(x0 - x3) * 8);
      m[4*r]   = wr(aa + bb);
      m[4*r+2] = wr(aa - bb);
      m[4*r+1] = wr((cc * 2217 + dd * 5352 + 14500) >>> 12);
      m[4*r+3] = wr((dd * 2217 - cc * 5352 + 7500) >>> 12);
    end
    for (int j = 0; j < 4; j++) begin
      int aa = wr(m[j] + m[12+j] + 7);
      int bb = wr(m[4+j] + m[8+j]);
      int cc = wr(m[4+j] - m[8+j]);
      int dd = wr(m[j] - m[12+j]);
      int sm = wr(aa + bb);
      int df = wr(aa - bb);
      exp_y[j]    = wr(sm >>> 4);
      exp_y[8+j]  = wr(df >>> 4);
      exp_y[4+j]  = wr(((cc * 2217 + dd * 5352 + 12000) >>> 16) + ((dd != 0) ? 1 : 0));
      exp_y[12+j] = wr((dd * 2217 - cc * 5352 + 51000) >>> 16);
    end
  endfunction

  function automatic logic [63:0] pack_row(input shortint v[16], input int r);
    return {v[4*r+3], v[4*r+2], v[4*r+1], v[4*r]};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Called at a negedge; returns at a negedge after the tile has drained.
  task automatic run_tile(input bit gaps, input bit stalls);
    string tag;
    compute_expect();
    for (int r = 0; r < 4; r++) begin
      if (gaps && ($urandom_range(1) == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = pack_row(blk, r);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(!in_ready && !out_valid, "R6 closed after fourth row",
          {62'd0, in_ready, out_valid}, 64'd0);
    @(negedge clk);
    check(out_valid && !in_ready, "R7 out_valid two cycles after last row / R9",
          {62'd0, in_ready, out_valid}, 64'd1);
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: tag = "R1 R3 coef row 0";
        1: tag = "R2 R4 coef row 1";
        2: tag = "R1 R3 coef row 2";
        default: tag = "R2 R5 coef row 3";
      endcase
      if (stalls && ($urandom_range(1) == 1)) begin
        logic [63:0] held;
        out_ready = 1'b0;
        held = out_data;
        @(negedge clk);
        check(out_valid && (out_data == held), "R7 hold on stall", out_data, held);
      end
      out_ready = 1'b1;
      while (!out_valid) @(negedge clk);
      check(out_data == pack_row(exp_y, k), tag, out_data, pack_row(exp_y, k));
      @(negedge clk);
      out_ready = 1'b0;
    end
    check(in_ready && !out_valid, "R9 input reopens after last row",
          {62'd0, in_ready, out_valid}, 64'd2);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(in_ready && !out_valid, "R8 reset state", {62'd0, in_ready, out_valid}, 64'd2);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R8 after reset release",
          {62'd0, in_ready, out_valid}, 64'd2);

    // all zeros: R4 correction must stay off
    foreach (blk[i]) blk[i] = 16'sd0;
    run_tile(1'b0, 1'b0);
    // full-scale positive and negative: R1 wrap
    foreach (blk[i]) blk[i] = 16'sd32767;
    run_tile(1'b0, 1'b0);
    foreach (blk[i]) blk[i] = -16'sd32768;
    run_tile(1'b0, 1'b1);
    // alternating full scale
    foreach (blk[i]) blk[i] = (i % 2 == 0) ? 16'sd32767 : -16'sd32768;
    run_tile(1'b1, 1'b0);
    // single impulses: R4 correction versus R5
    for (int p = 0; p < 16; p += 5) begin
      foreach (blk[i]) blk[i] = 16'sd0;
      blk[p] = 16'sd1;
      run_tile(1'b0, 1'b0);
    end
    // constrained random tiles, back to back with random gaps and stalls
    for (int n = 0; n < 30; n++) begin
      foreach (blk[i]) blk[i] = shortint'(int'($urandom_range(510)) - 255);
      run_tile(1'b1, 1'b1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule